// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block sits next to a small 8-bit processor core and decides which of five interrupt sources is taken: two external request lines, two timer overflow flags and a serial flag that is the OR of a receive flag and a transmit flag. Software programs an enable register and a level register through a minimal register port. Each source is assigned either the high level or the low level. Within a level a fixed polling order decides the winner.

The block tracks which levels are currently being serviced. A high-level request can interrupt a running low-level handler. A request at the same level as the running handler, or any request while a high-level handler runs, is held back. When the core signals an instruction boundary and a request is eligible, the block pulses a take strobe for one cycle and presents the fixed 16-bit entry address of the winning source. A return strobe from the core retires the innermost active level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: There are five sources with index 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. `srcReq[3:0]` carries sources 0..3. Source 4 requests when `serRxFlag` or `serTxFlag` is 1.
- R2: A source is eligible only when the global enable (bit 7 of the enable register) and its own enable bit (enable register bit equal to its index) are both 1.
- R3: After reset, both registers read 0, no level is in service, and `takeIrq` is 0.
- R4: `regAddr`=0 selects the enable register and `regAddr`=1 selects the level register. A write happens on a clock edge with `regWrEn`=1. `regRdData` shows the selected register combinationally. Enable bits 6 and 5 and level bits 7..5 always read 0.
- R5: Level register bit i = 1 puts source i at the high level, and 0 puts it at the low level. If any eligible high-level source exists, one of them wins over every low-level source.
- R6: Within one level, the eligible source with the smallest index wins.
- R7: The entry address of source i is 0x0003 + 8*i (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R8: On a rising edge where `instrBoundary`=1 and a winner is allowed, `takeIrq` is 1 during the following cycle and `vecAddr` holds the winner's address. `takeIrq` is never 1 unless `instrBoundary` was 1 at the preceding edge.
- R9: A high-level request is taken while a low-level handler is in service.
- R10: While a high-level handler is in service, nothing is taken. While a low-level handler is in service, low-level requests wait.
- R11: A `retStrobe` cycle clears the high in-service level if it is set, and otherwise clears the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = enable register, 1 = level register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| srcReq | input | 4 | Requests of sources 0..3 |
| serRxFlag | input | 1 | Serial receive flag |
| serTxFlag | input | 1 | Serial transmit flag |
| instrBoundary | input | 1 | Core is at an instruction boundary |
| retStrobe | input | 1 | Core returned from a handler |
| takeIrq | output | 1 | One-cycle take strobe |
| vecAddr | output | 16 | Entry address of the taken source |

## Verification
The hardest state to reach is two handlers stacked at once: a low-level handler with a high-level handler preempting it. In that state, further requests must stay blocked until the returns unwind in the right order. The bench builds this up step by step. It takes a low source and then raises a high source. It then probes with a same-level request and with a second high request, and issues returns one at a time, checking after each return which requests may be taken. Arbitration itself is swept over all request patterns against all level patterns, and over all enable patterns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC       = 5;
  localparam int IDX_W         = $clog2(NUM_SRC);
  localparam int DATA_W        = 8;
  localparam int VEC_W         = 16;
  localparam int GLOBAL_EN_BIT = 7;
  localparam int VEC_BASE      = 3;
  localparam int VEC_STRIDE    = 8;

  typedef struct packed {
    logic             fire;
    logic [IDX_W-1:0] srcIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_dp.sv
module irq_dp
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_SRC-1:0] srcLine,
  input  ctlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] pendHigh,
  output logic [NUM_SRC-1:0] pendLow,
  output logic              enGlobal,
  output logic              takeIrq,
  output logic [VEC_W-1:0]  vecAddr
);
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] levelMask;
  logic               enAll;
  logic [NUM_SRC-1:0] eligible;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask    <= '0;
      enAll     <= 1'b0;
      levelMask <= '0;
    end else if (regWrEn) begin
      if (!regAddr) begin
        enMask <= regWrData[NUM_SRC-1:0];
        enAll  <= regWrData[GLOBAL_EN_BIT];
      end else begin
        levelMask <= regWrData[NUM_SRC-1:0];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[NUM_SRC-1:0]     = enMask;
      regRdData[GLOBAL_EN_BIT]   = enAll;
    end else begin
      regRdData[NUM_SRC-1:0]     = levelMask;
    end
  end

  assign eligible = srcLine & enMask & {NUM_SRC{enAll}};
  assign pendHigh = eligible & levelMask;
  assign pendLow  = eligible & ~levelMask;
  assign enGlobal = enAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeIrq <= 1'b0;
      vecAddr <= '0;
    end else begin
      takeIrq <= strobe.fire;
      if (strobe.fire)
        vecAddr <= VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(strobe.srcIdx);
    end
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendHigh,
  input  logic [NUM_SRC-1:0] pendLow,
  input  logic               instrBoundary,
  input  logic               retStrobe,
  output ctlStrobe_t         strobe,
  output logic               inSvcHigh,
  output logic               inSvcLow
);
  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic canHigh, canLow, winHigh;
  logic nextHigh, nextLow;

  assign canHigh = !inSvcHigh && (|pendHigh);
  assign canLow  = !inSvcHigh && !inSvcLow && (|pendLow);
  assign winHigh = canHigh;

  always_comb begin
    strobe.fire   = instrBoundary && (canHigh || canLow);
    strobe.srcIdx = winHigh ? firstSet(pendHigh) : firstSet(pendLow);
  end

  always_comb begin
    nextHigh = inSvcHigh;
    nextLow  = inSvcLow;
    if (retStrobe) begin
      if (inSvcHigh) nextHigh = 1'b0;
      else           nextLow  = 1'b0;
    end
    if (strobe.fire) begin
      if (winHigh) nextHigh = 1'b1;
      else         nextLow  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvcHigh <= 1'b0;
      inSvcLow  <= 1'b0;
    end else begin
      inSvcHigh <= nextHigh;
      inSvcLow  <= nextLow;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [3:0]  srcReq,
  input  logic        serRxFlag,
  input  logic        serTxFlag,
  input  logic        instrBoundary,
  input  logic        retStrobe,
  output logic        takeIrq,
  output logic [15:0] vecAddr
);
  logic [NUM_SRC-1:0] srcLine;
  logic [NUM_SRC-1:0] pendHigh, pendLow;
  ctlStrobe_t         strobe;
  logic               enGlobal, inSvcHigh, inSvcLow;

  // R1: the serial source merges its two flags
  assign srcLine = {serRxFlag | serTxFlag, srcReq};

  irq_dp u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcLine(srcLine),
    .strobe(strobe), .pendHigh(pendHigh), .pendLow(pendLow),
    .enGlobal(enGlobal), .takeIrq(takeIrq), .vecAddr(vecAddr)
  );

  irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .pendHigh(pendHigh), .pendLow(pendLow),
    .instrBoundary(instrBoundary), .retStrobe(retStrobe),
    .strobe(strobe), .inSvcHigh(inSvcHigh), .inSvcLow(inSvcLow)
  );
endmodule

// File: rtl/irq_chk.sv
module irq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        takeIrq,
  input logic [15:0] vecAddr,
  input logic        instrBoundary,
  input logic        enGlobal,
  input logic        inSvcHigh,
  input logic        regAddr,
  input logic [7:0]  regRdData
);
  // R7
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vecAddr[2:0] == 3'd3 && vecAddr <= 16'h0023));
  // R8
  take_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrBoundary));
  // R2
  take_global_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(enGlobal));
  // R10
  high_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSvcHigh |=> !takeIrq);
  // R4
  level_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> regRdData[7:5] == 3'b000);
endmodule

bind prio_irq_ctrl irq_chk u_chk (
  .clk(clk), .rstN(rstN), .takeIrq(takeIrq), .vecAddr(vecAddr),
  .instrBoundary(instrBoundary), .enGlobal(enGlobal), .inSvcHigh(inSvcHigh),
  .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regAddr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic [3:0] srcReq = 0;
  logic serRxFlag = 0, serTxFlag = 0, instrBoundary = 0, retStrobe = 0;
  logic takeIrq;
  logic [15:0] vecAddr;
  int nChecks = 0, nFails = 0;

  prio_irq_ctrl dut (.*);

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(bit a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rdReg(bit a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic setReq(logic [4:0] r, bit useTx);
    srcReq = r[3:0]; serRxFlag = r[4] & !useTx; serTxFlag = r[4] & useTx;
  endtask

  // pulse the boundary for one edge and sample the result afterwards
  task automatic stepB(output bit tk, output int v);
    instrBoundary = 1;
    @(negedge clk); instrBoundary = 0;
    tk = takeIrq; v = vecAddr;
  endtask

  task automatic doRet();
    retStrobe = 1; @(negedge clk); retStrobe = 0;
  endtask

  function automatic int expWin(logic [4:0] r, logic [4:0] en, bit ga, logic [4:0] lv);
    logic [4:0] p, h;
    p = ga ? (r & en) : 5'd0;
    h = p & lv;
    for (int i = 0; i < 5; i++) if (h[i]) return i;
    for (int i = 0; i < 5; i++) if (p[i]) return i;
    return -1;
  endfunction

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit tk; int v, w;
    repeat (3) @(negedge clk);
    // R3 reset state
    check(takeIrq == 0, "R3 take in reset", takeIrq, 0);
    rstN = 1;
    rdReg(0, d); check(d == 0, "R3 enable reset", d, 0);
    rdReg(1, d); check(d == 0, "R3 level reset", d, 0);
    // R3 disabled after reset: nothing taken
    setReq(5'h1F, 0); stepB(tk, v);
    check(tk == 0, "R3 no take after reset", tk, 0);
    setReq(0, 0);
    // R4 readback and reserved bits
    wrReg(0, 8'hFF); rdReg(0, d); check(d == 8'h9F, "R4 enable readback", d, 8'h9F);
    wrReg(1, 8'hFF); rdReg(1, d); check(d == 8'h1F, "R4 level readback", d, 8'h1F);
    wrReg(1, 8'hE0); rdReg(1, d); check(d == 8'h00, "R4 level reserved", d, 0);
    wrReg(0, 8'h9F);
    // R5 R6 R7 R1: sweep levels x requests
    for (int lv = 0; lv < 32; lv++) begin
      wrReg(1, 8'(lv));
      for (int r = 0; r < 32; r++) begin
        @(negedge clk); setReq(5'(r), lv[0]);
        stepB(tk, v);
        w = expWin(5'(r), 5'h1F, 1, 5'(lv));
        check(tk == (w >= 0), "R5 R6 R1 take", tk, (w >= 0));
        if (w >= 0) check(v == 3 + 8 * w, "R7 R6 R5 vector", v, 3 + 8 * w);
        setReq(0, 0); doRet(); doRet();
      end
    end
    // R2 sweep enables with and without global enable
    wrReg(1, 8'h00);
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 32; e++) begin
        wrReg(0, {g[0], 2'b00, 5'(e)});
        setReq(5'h1F, 1);
        stepB(tk, v);
        w = expWin(5'h1F, 5'(e), g[0], 5'h00);
        check(tk == (w >= 0), "R2 gated take", tk, (w >= 0));
        if (w >= 0) check(v == 3 + 8 * w, "R2 gated vector", v, 3 + 8 * w);
        setReq(0, 0); doRet();
      end
    // R8 no boundary, no take; single-cycle pulse
    wrReg(0, 8'h9F);
    setReq(5'h04, 0);
    repeat (3) @(negedge clk);
    check(takeIrq == 0, "R8 no boundary", takeIrq, 0);
    stepB(tk, v);
    check(tk == 1 && v == 16'h13, "R8 take ext1", v, 16'h13);
    @(negedge clk);
    check(takeIrq == 0, "R8 one cycle", takeIrq, 0);
    // nesting: level reg: timer1 and serial high
    wrReg(1, 8'h18);
    // low ext1 in service; R10 low ext0 waits
    srcReq = 4'b0101; stepB(tk, v);
    check(tk == 0, "R10 same low level waits", tk, 0);
    // R9 high timer1 preempts
    srcReq = 4'b1101; stepB(tk, v);
    check(tk == 1 && v == 16'h1B, "R9 preempt vector", v, 16'h1B);
    srcReq = 4'b0101;
    // R10 high serial blocked by high in service
    serRxFlag = 1; stepB(tk, v);
    check(tk == 0, "R10 high blocks high", tk, 0);
    // R11 return clears high; serial high now taken
    doRet(); stepB(tk, v);
    check(tk == 1 && v == 16'h23, "R11 after high return", v, 16'h23);
    serRxFlag = 0; doRet();
    // low still in service
    stepB(tk, v);
    check(tk == 0, "R11 low still in service", tk, 0);
    doRet(); stepB(tk, v);
    check(tk == 1 && v == 16'h03, "R11 after low return", v, 16'h03);
    setReq(0, 0); doRet();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule